// File: doc/BRIEF.md
# ECC Error Capture Register File

This block sits beside a memory controller's ECC checker and keeps a software-visible record of memory errors. The checker raises a one-cycle pulse for a correctable single-bit error or an uncorrectable multi-bit error. With the pulse it presents the failing physical address and the memory row that was accessed. The block first qualifies each pulse against the programmed integrity mode and a per-row ECC-capable mask. It then stores the 4 KB page of the failing address and sets a sticky flag for each error kind. For each kind it also keeps the row of the first error seen. Software can ask for a one-cycle system-error pulse on either kind.

The logged page and both first-error rows stay frozen while their flags are set. Software releases them by writing 1 to the flag bits in the address register, and only then can a new error be recorded. The integrity mode selects what happens to a qualified single-bit error. In detect-only mode it is only reported. In correct mode it also raises a correction indication. In scrub mode it raises the correction indication and a scrub request. A small word-wide read/write port reaches four registers. Reads are combinational in the default configuration.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and serr_pulse, corr_pulse and scrub_pulse are low.
- R2: The configuration register (select 0) holds the integrity mode in bits 1:0 and a per-row ECC-capable mask in bits 15:8, with bit 8+n for row n. An error pulse has no effect at all when the mode is 00 or when the mask bit of the error's row is 0.
- R3: The address register (select 2) returns the failing address bits 31:12 in bits 31:12. Bit 0 is the single-bit flag and bit 1 is the multi-bit flag. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R4: While either flag is set, the logged page does not change. After both flags are cleared, the next qualified error logs its page. An error that arrives in the same cycle as the clearing write is recorded.
- R5: The status register (select 3) has bit 0 = single-bit flag, bits 3:1 = row of the first single-bit error, bit 4 = multi-bit flag, and bits 7:5 = row of the first multi-bit error. A row field holds until its flag is cleared, and clearing the flag zeroes the row field.
- R6: A single-bit and a multi-bit pulse in the same cycle set both flags and both row fields, and the address of that cycle is logged.
- R7: The command register (select 1) bit 0 enables, and bit 1 enables, a system-error pulse for newly captured single-bit and multi-bit errors respectively. serr_pulse is high for exactly the one cycle after the capturing edge. An error whose flag is already set raises no pulse.
- R8: A qualified single-bit error raises corr_pulse for one cycle in modes 10 and 11, and never in mode 01. scrub_pulse rises only in mode 11.
- R9: Writes to read-only fields are ignored: the status register, the address bits 31:2, and the unused bits of the configuration and command registers, which read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sbe_pulse | input | 1 | Single-bit error seen by the checker |
| mbe_pulse | input | 1 | Multi-bit error seen by the checker |
| err_addr | input | 32 | Physical address of the failing access |
| err_row | input | 3 | Memory row of the failing access |
| reg_sel | input | 2 | Register select: 0 config, 1 command, 2 address, 3 status |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| serr_pulse | output | 1 | System-error pulse |
| corr_pulse | output | 1 | Correction indication |
| scrub_pulse | output | 1 | Scrub request |

## Verification
A stuck or lost flag shows in the address and status registers on the first read after the capturing edge. It also shows on the next error, which then either logs a page that should have stayed frozen or raises no system-error pulse. A wrong qualification decision shows one cycle after the error pulse, on serr_pulse and corr_pulse. A sweep over every mode, every row of a mixed ECC mask and every error-kind combination therefore exposes it within two cycles of the stimulus. Row fields that are not zeroed on a clear, or that are overwritten while frozen, show on the following status read.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;
   typedef enum logic [1:0] {
      MODE_OFF     = 2'b00,
      MODE_DETECT  = 2'b01,
      MODE_CORRECT = 2'b10,
      MODE_SCRUB   = 2'b11
   } integ_mode_e;

   typedef enum logic [1:0] {
      RSEL_CFG  = 2'd0,
      RSEL_CMD  = 2'd1,
      RSEL_ADDR = 2'd2,
      RSEL_STAT = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic mbe;
      logic sbe;
   } err_pair_t;

   localparam int STAT_ROW_W = 3;
   localparam int MASK_LSB   = 8;
endpackage

// File: rtl/ecc_err_qual.sv
module ecc_err_qual
   import ecc_err_log_pkg::*;
#(
   parameter int ROWS  = 8,
   parameter int ROW_W = 3
) (
   input  integ_mode_e      mode,
   input  logic [ROWS-1:0]  row_mask,
   input  logic [ROW_W-1:0] row,
   input  logic             sbe_in,
   input  logic             mbe_in,
   output err_pair_t        qual
);
   logic row_ok;

   always_comb begin
      row_ok = 1'b0;
      for (int i = 0; i < ROWS; i++) begin
         if (int'(row) == i) row_ok = row_mask[i];
      end
   end

   always_comb begin
      qual.sbe = sbe_in && row_ok && (mode != MODE_OFF);
      qual.mbe = mbe_in && row_ok && (mode != MODE_OFF);
   end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
   import ecc_err_log_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PAGE_LSB = 12,
   parameter int ROW_W    = 3,
   localparam int PAGE_W  = ADDR_W - PAGE_LSB
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  err_pair_t             qual,
   input  err_pair_t             clr,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [ROW_W-1:0]      row,
   output err_pair_t             flags,
   output err_pair_t             fresh,
   output logic [PAGE_W-1:0]     page,
   output logic [STAT_ROW_W-1:0] sbe_row,
   output logic [STAT_ROW_W-1:0] mbe_row
);
   err_pair_t held;

   always_comb begin
      held.sbe  = flags.sbe && !clr.sbe;
      held.mbe  = flags.mbe && !clr.mbe;
      fresh.sbe = qual.sbe && !held.sbe;
      fresh.mbe = qual.mbe && !held.mbe;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags   <= '0;
         page    <= '0;
         sbe_row <= '0;
         mbe_row <= '0;
      end else begin
         flags.sbe <= held.sbe || fresh.sbe;
         flags.mbe <= held.mbe || fresh.mbe;
         if ((fresh.sbe || fresh.mbe) && !held.sbe && !held.mbe)
            page <= addr[ADDR_W-1:PAGE_LSB];
         if (fresh.sbe)    sbe_row <= STAT_ROW_W'(row);
         else if (clr.sbe) sbe_row <= '0;
         if (fresh.mbe)    mbe_row <= STAT_ROW_W'(row);
         else if (clr.mbe) mbe_row <= '0;
      end
   end
endmodule

// File: rtl/ecc_err_signal.sv
module ecc_err_signal
   import ecc_err_log_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  integ_mode_e mode,
   input  logic [1:0]  cmd,
   input  err_pair_t   qual,
   input  err_pair_t   fresh,
   output logic        serr,
   output logic        corr,
   output logic        scrub
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         serr  <= 1'b0;
         corr  <= 1'b0;
         scrub <= 1'b0;
      end else begin
         serr  <= (fresh.sbe && cmd[0]) || (fresh.mbe && cmd[1]);
         corr  <= qual.sbe && (mode == MODE_CORRECT || mode == MODE_SCRUB);
         scrub <= qual.sbe && (mode == MODE_SCRUB);
      end
   end
endmodule

// File: rtl/ecc_err_regif.sv
module ecc_err_regif
   import ecc_err_log_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ROWS     = 8,
   parameter int ADDR_W   = 32,
   parameter int PAGE_LSB = 12,
   parameter bit RDATA_REG = 1'b0,
   localparam int PAGE_W  = ADDR_W - PAGE_LSB
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  reg_sel_e              sel,
   input  logic                  we,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata,
   output integ_mode_e           mode,
   output logic [ROWS-1:0]       row_mask,
   output logic [1:0]            cmd,
   output err_pair_t             clr,
   input  err_pair_t             flags,
   input  logic [PAGE_W-1:0]     page,
   input  logic [STAT_ROW_W-1:0] sbe_row,
   input  logic [STAT_ROW_W-1:0] mbe_row
);
   logic [DATA_W-1:0] rd_mux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= MODE_OFF;
         row_mask <= '0;
         cmd      <= '0;
      end else if (we) begin
         if (sel == RSEL_CFG) begin
            mode     <= integ_mode_e'(wdata[1:0]);
            row_mask <= wdata[MASK_LSB +: ROWS];
         end
         if (sel == RSEL_CMD) cmd <= wdata[1:0];
      end
   end

   always_comb begin
      clr.sbe = we && (sel == RSEL_ADDR) && wdata[0];
      clr.mbe = we && (sel == RSEL_ADDR) && wdata[1];
   end

   always_comb begin
      rd_mux = '0;
      unique case (sel)
         RSEL_CFG:  rd_mux = DATA_W'({row_mask, 6'b0, mode});
         RSEL_CMD:  rd_mux = DATA_W'(cmd);
         RSEL_ADDR: rd_mux = DATA_W'({page, {(PAGE_LSB-2){1'b0}}, flags.mbe, flags.sbe});
         RSEL_STAT: rd_mux = DATA_W'({mbe_row, flags.mbe, sbe_row, flags.sbe});
         default:   rd_mux = '0;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
   import ecc_err_log_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 32,
   parameter int PAGE_LSB  = 12,
   parameter int ROWS      = 8,
   parameter bit RDATA_REG = 1'b0,
   localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int PAGE_W   = ADDR_W - PAGE_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sbe_pulse,
   input  logic              mbe_pulse,
   input  logic [ADDR_W-1:0] err_addr,
   input  logic [ROW_W-1:0]  err_row,
   input  logic [1:0]        reg_sel,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              serr_pulse,
   output logic              corr_pulse,
   output logic              scrub_pulse
);
   generate
      if (ROWS < 2 || ROWS > 8) begin : g_bad_rows
         $error("ecc_err_log: ROWS must be 2..8");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("ecc_err_log: ADDR_W must not exceed DATA_W");
      end
      if (PAGE_LSB < 3 || PAGE_LSB >= ADDR_W) begin : g_bad_page
         $error("ecc_err_log: PAGE_LSB out of range");
      end
      if (DATA_W < MASK_LSB + 8) begin : g_bad_data
         $error("ecc_err_log: DATA_W too narrow");
      end
   endgenerate

   integ_mode_e           cfg_mode;
   logic [ROWS-1:0]       cfg_mask;
   logic [1:0]            cmd_en;
   err_pair_t             qual, fresh, flags, clr;
   logic [PAGE_W-1:0]     log_page;
   logic [STAT_ROW_W-1:0] sbe_row, mbe_row;

   ecc_err_qual #(.ROWS(ROWS), .ROW_W(ROW_W)) u_qual (
      .mode(cfg_mode), .row_mask(cfg_mask), .row(err_row),
      .sbe_in(sbe_pulse), .mbe_in(mbe_pulse), .qual(qual)
   );

   ecc_err_capture #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .ROW_W(ROW_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .qual(qual), .clr(clr), .addr(err_addr),
      .row(err_row), .flags(flags), .fresh(fresh), .page(log_page),
      .sbe_row(sbe_row), .mbe_row(mbe_row)
   );

   ecc_err_signal u_sig (
      .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .cmd(cmd_en),
      .qual(qual), .fresh(fresh), .serr(serr_pulse), .corr(corr_pulse),
      .scrub(scrub_pulse)
   );

   ecc_err_regif #(.DATA_W(DATA_W), .ROWS(ROWS), .ADDR_W(ADDR_W),
                   .PAGE_LSB(PAGE_LSB), .RDATA_REG(RDATA_REG)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(reg_sel_e'(reg_sel)), .we(reg_we),
      .wdata(reg_wdata), .rdata(reg_rdata), .mode(cfg_mode),
      .row_mask(cfg_mask), .cmd(cmd_en), .clr(clr), .flags(flags),
      .page(log_page), .sbe_row(sbe_row), .mbe_row(mbe_row)
   );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
   parameter int PAGE_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              flag_s,
   input logic              flag_m,
   input logic              clr_s,
   input logic              clr_m,
   input logic [PAGE_W-1:0] page,
   input logic [2:0]        row_s,
   input logic [2:0]        row_m,
   input logic              sbe_pulse,
   input logic              mbe_pulse,
   input logic              serr,
   input logic              corr,
   input logic              scrub
);
   a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> (!serr && !corr && !scrub));

   a_r4_page_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_s && !clr_s) || (flag_m && !clr_m)) |=> $stable(page));

   a_r5_sbe_row_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_s && !clr_s) |=> $stable(row_s));

   a_r5_mbe_row_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_m && !clr_m) |=> $stable(row_m));

   a_r7_serr_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      serr |-> $past(sbe_pulse || mbe_pulse));

   a_r8_detect_no_corr: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |=> (!corr && !scrub));

   a_r8_scrub_with_corr: assert property (@(posedge clk) disable iff (!rst_n)
      scrub |-> corr);
endmodule

bind ecc_err_log ecc_err_log_chk #(.PAGE_W(PAGE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .flag_s(flags.sbe),
   .flag_m(flags.mbe), .clr_s(clr.sbe), .clr_m(clr.mbe), .page(log_page),
   .row_s(sbe_row), .row_m(mbe_row), .sbe_pulse(sbe_pulse),
   .mbe_pulse(mbe_pulse), .serr(serr_pulse), .corr(corr_pulse),
   .scrub(scrub_pulse)
);

// File: tb/ecc_err_log_tb_top.sv
module ecc_err_log_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sbe_pulse = 1'b0, mbe_pulse = 1'b0;
   logic [31:0] err_addr = '0;
   logic [2:0]  err_row = '0;
   logic [1:0]  reg_sel = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        serr_pulse, corr_pulse, scrub_pulse;

   int total = 0;
   int bad = 0;
   logic [19:0] exp_page = '0;

   always #10 clk = ~clk;

   ecc_err_log dut_i (
      .clk(clk), .rst_n(rst_n), .sbe_pulse(sbe_pulse), .mbe_pulse(mbe_pulse),
      .err_addr(err_addr), .err_row(err_row), .reg_sel(reg_sel),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .serr_pulse(serr_pulse), .corr_pulse(corr_pulse),
      .scrub_pulse(scrub_pulse)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_sel = sel; reg_wdata = data; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] data);
      reg_sel = sel;
      #1;
      data = reg_rdata;
   endtask

   // drive one error cycle and return the registered pulses seen after it
   task automatic hit(input logic s, input logic m, input logic [2:0] row,
                      input logic [31:0] addr, output logic [2:0] pulses);
      @(negedge clk);
      sbe_pulse = s; mbe_pulse = m; err_row = row; err_addr = addr;
      @(negedge clk);
      sbe_pulse = 1'b0; mbe_pulse = 1'b0;
      pulses = {serr_pulse, corr_pulse, scrub_pulse};
   endtask

   initial begin
      logic [31:0] v;
      logic [2:0]  p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int s = 0; s < 4; s++) begin
         rd(2'(s), v);
         check("R1 reg after reset", v, 32'h0);
      end
      check("R1 pulses after reset", {29'h0, serr_pulse, corr_pulse, scrub_pulse}, 32'h0);

      // sweep: mode x row x kind with mask 0xA5 (rows 0,2,5,7 ECC)
      for (int md = 0; md < 4; md++) begin
         for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 3; k++) begin
               logic [7:0]  mask;
               logic [1:0]  cmd;
               logic        q, es, em;
               logic [31:0] a;
               logic [2:0]  ep;
               mask = 8'hA5;
               cmd  = 2'((md ^ r) & 3);
               a    = 32'h1000_0000 + 32'((md*24 + r*3 + k) * 32'h11000) + 32'h7A4;
               wr(2'd0, {16'h0, mask, 6'h0, 2'(md)});
               wr(2'd1, {30'h0, cmd});
               wr(2'd2, 32'h3);
               hit(k != 1, k != 0, 3'(r), a, p);
               q  = (md != 0) && mask[r];
               es = q && (k != 1);
               em = q && (k != 0);
               if (es || em) exp_page = a[31:12];
               ep[2] = (es && cmd[0]) || (em && cmd[1]);
               ep[1] = es && (md >= 2);
               ep[0] = es && (md == 3);
               check("R7/R8 pulses", {29'h0, p}, {29'h0, ep});
               rd(2'd2, v);
               check("R2/R3/R6 addr reg", v, {exp_page, 10'h0, em, es});
               rd(2'd3, v);
               check("R5/R6 status", v,
                     {24'h0, em ? 3'(r) : 3'd0, em, es ? 3'(r) : 3'd0, es});
               @(negedge clk);
               check("R7 serr one cycle", {31'h0, serr_pulse}, 32'h0);
            end
         end
      end

      // freeze behaviour, mode 10, all rows ECC, both serr enables
      wr(2'd0, 32'h0000_FF02);
      wr(2'd1, 32'h3);
      wr(2'd2, 32'h3);
      hit(1, 0, 3'd3, 32'hABCDE123, p);
      check("R7 serr first sbe", {29'h0, p}, 32'h6);
      hit(1, 0, 3'd5, 32'h12345000, p);
      check("R7 no serr repeated sbe", {29'h0, p}, 32'h2);
      rd(2'd3, v);
      check("R5 sbe row held", v, 32'h0000_0007);
      hit(0, 1, 3'd6, 32'h55555000, p);
      check("R7 serr on first mbe", {29'h0, p}, 32'h4);
      rd(2'd2, v);
      check("R4 page frozen", v, 32'hABCDE003);
      rd(2'd3, v);
      check("R5 both rows", v, 32'h0000_00D7);
      wr(2'd2, 32'h1);
      rd(2'd3, v);
      check("R5 clear sbe zeroes row", v, 32'h0000_00D0);
      rd(2'd2, v);
      check("R3 partial clear", v, 32'hABCDE002);
      wr(2'd2, 32'h2);
      rd(2'd2, v);
      check("R3 all clear page kept", v, 32'hABCDE000);
      hit(1, 0, 3'd2, 32'h0F0F0FFF, p);
      rd(2'd2, v);
      check("R4 new capture after clear", v, 32'h0F0F0001);

      // clear and new error in the same cycle
      @(negedge clk);
      reg_sel = 2'd2; reg_wdata = 32'h1; reg_we = 1'b1;
      sbe_pulse = 1'b1; err_row = 3'd1; err_addr = 32'h77777000;
      @(negedge clk);
      reg_we = 1'b0; sbe_pulse = 1'b0;
      check("R4 serr on clear+event", {31'h0, serr_pulse}, 32'h1);
      rd(2'd2, v);
      check("R4 event during clear logged", v, 32'h77777001);
      rd(2'd3, v);
      check("R5 row from clear cycle", v, 32'h0000_0003);

      // R9 read-only fields
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd3, v);
      check("R9 status ignores write", v, 32'h0000_0003);
      wr(2'd2, 32'hFFFF_F000);
      rd(2'd2, v);
      check("R9 address bits ignore write", v, 32'h77777001);
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v);
      check("R9 config unused bits", v, 32'h0000_FF03);
      wr(2'd1, 32'hFFFF_FFFC);
      rd(2'd1, v);
      check("R9 command unused bits", v, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule